// File: doc/BRIEF.md
# Real-Mode Interrupt Entry and Return Sequencer

This block is the multi-cycle engine a 16-bit real-mode core uses to take a software interrupt and to come back from a procedure. It owns the core's FLAGS, CS, IP and SP registers. On an interrupt request carrying an 8-bit vector number it saves the machine state on the stack, masks single-stepping and maskable interrupts, and loads the new code address from the vector table at the bottom of memory. On a return request it restores IP, or IP and CS, from the stack and can then drop a caller-supplied number of argument bytes. A separate one-cycle request sets the interrupt-enable flag alone.

All memory traffic uses one word-wide port with a request/ready handshake: a transfer completes on each clock edge where the request and ready are both high, so with ready held high one word moves per cycle. The stack lives at the 20-bit physical address formed from the stack segment (shifted left four bits) plus SP, wrapping modulo 2^20. The core fills the registers through a load port while the block is idle and reads them back on the register outputs.

Top module: `rm_irq_seq`

## Requirements
- R1: While reset is asserted and after it, with no request, busy and mem_req are low and flags_o, cs_o, ip_o and sp_o read 0.
- R2: A request with op 2'b00 (interrupt) writes three words in this order: FLAGS as it was before the request, then CS, then IP; before each write SP drops by 2 (modulo 2^16) and the word goes to byte address ss_i*16 + SP (modulo 2^20).
- R3: When an interrupt completes, FLAGS bit 8 (trap) and bit 9 (interrupt enable) read 0, every other FLAGS bit is unchanged, and SP is 6 below its starting value.
- R4: After its pushes an interrupt reads byte address 4*n for the new IP, then 4*n+2 for the new CS, where n is req_vec; both registers take these values when it completes.
- R5: A request with op 2'b10 (far return) reads IP from ss_i*16+SP, then CS from the next word, and finishes with SP = old SP + 4 + req_imm.
- R6: A request with op 2'b01 (near return) reads only IP, leaves CS unchanged, and finishes with SP = old SP + 2 + req_imm.
- R7: A request with op 2'b11 sets FLAGS bit 9 on the next edge, changes no other bit and no other register, makes no memory access and leaves busy low.
- R8: busy rises on the edge that accepts an interrupt or return and falls on the edge of its final register update; requests arriving while busy are ignored.
- R9: A transfer completes only on an edge with mem_req and mem_rdy both high; while mem_req waits for mem_rdy, mem_addr, mem_we and mem_wdata hold.
- R10: When idle, ld_en loads FLAGS, CS, IP and SP from the ld_* inputs on the next edge and takes priority over a request in the same cycle, which is dropped; ld_en is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 interrupt, 01 near return, 10 far return, 11 set interrupt enable |
| req_vec | input | 8 | Interrupt vector number |
| req_imm | input | 16 | Extra bytes released after a return |
| ld_en | input | 1 | Load registers from ld_* |
| ld_flags | input | 16 | FLAGS load value |
| ld_cs | input | 16 | CS load value |
| ld_ip | input | 16 | IP load value |
| ld_sp | input | 16 | SP load value |
| ss_i | input | 16 | Stack segment |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts the transfer |
| flags_o | output | 16 | FLAGS register |
| cs_o | output | 16 | CS register |
| ip_o | output | 16 | IP register |
| sp_o | output | 16 | SP register |

## Verification
The bench aims at the ordering of the interrupt pushes and the point where the trap and enable bits are cleared: a design that cleared them before the first push would store a FLAGS word with both bits already zero, and one that swapped CS and IP would produce a wrong-order write stream in the scoreboard. Returns are run with and without a release count, near and far, so a design that forgot the count or popped CS on a near return ends with a wrong SP or CS. SP wrap from 0 and physical address wrap past 2^20 are both driven, as are memory stalls and requests and loads thrown in mid-sequence, which a design that accepted them would turn into extra transfers or corrupted registers. The load-versus-request collision checks that the request is dropped rather than started.

// File: rtl/rmis_pkg.sv
package rmis_pkg;
  localparam int RMIS_DW = 16;
  localparam int RMIS_AW = 20;
  localparam int RMIS_VW = 8;
  localparam int RMIS_SEG_SHIFT = 4;
  localparam int RMIS_TF_BIT = 8;
  localparam int RMIS_IF_BIT = 9;

  typedef enum logic [1:0] {
    OP_INT   = 2'b00,
    OP_RETN  = 2'b01,
    OP_RETF  = 2'b10,
    OP_SETIF = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_F,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_RD_IP,
    ST_RD_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_FIN
  } st_e;
endpackage

// File: rtl/rmis_fsm.sv
module rmis_fsm
  import rmis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  op_e  op,
  input  logic step,
  output st_e  state
);
  st_e  st_d, st_q;
  logic far_d, far_q;

  always_comb begin
    st_d  = st_q;
    far_d = far_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        far_d = (op == OP_RETF);
        st_d  = (op == OP_INT) ? ST_PUSH_F : ST_POP_IP;
      end
      ST_PUSH_F:  if (step) st_d = ST_PUSH_CS;
      ST_PUSH_CS: if (step) st_d = ST_PUSH_IP;
      ST_PUSH_IP: if (step) st_d = ST_RD_IP;
      ST_RD_IP:   if (step) st_d = ST_RD_CS;
      ST_RD_CS:   if (step) st_d = ST_IDLE;
      ST_POP_IP:  if (step) st_d = far_q ? ST_POP_CS : ST_FIN;
      ST_POP_CS:  if (step) st_d = ST_FIN;
      ST_FIN:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      far_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      far_q <= far_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/rmis_agen.sv
module rmis_agen
  import rmis_pkg::*;
#(
  parameter int DW = RMIS_DW,
  parameter int AW = RMIS_AW,
  parameter int VW = RMIS_VW
) (
  input  st_e           state,
  input  logic [DW-1:0] ss,
  input  logic [DW-1:0] sp,
  input  logic [VW-1:0] vec,
  input  logic [DW-1:0] flags,
  input  logic [DW-1:0] cs,
  input  logic [DW-1:0] ip,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int VPAD = AW - VW - 2;

  logic [AW-1:0] stk_addr;
  logic [AW-1:0] vec_base;

  assign stk_addr = ({{(AW-DW){1'b0}}, ss} << RMIS_SEG_SHIFT) + {{(AW-DW){1'b0}}, sp};
  assign vec_base = {{VPAD{1'b0}}, vec, 2'b00};

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = stk_addr;
    mem_wdata = '0;
    case (state)
      ST_PUSH_F:  begin mem_we = 1'b1; mem_wdata = flags; end
      ST_PUSH_CS: begin mem_we = 1'b1; mem_wdata = cs;    end
      ST_PUSH_IP: begin mem_we = 1'b1; mem_wdata = ip;    end
      ST_RD_IP:   mem_addr = vec_base;
      ST_RD_CS:   mem_addr = vec_base | {{(AW-2){1'b0}}, 2'b10};
      ST_POP_IP, ST_POP_CS: mem_addr = stk_addr;
      default: begin mem_req = 1'b0; mem_addr = '0; end
    endcase
  end
endmodule

// File: rtl/rmis_regs.sv
module rmis_regs
  import rmis_pkg::*;
#(
  parameter int DW = RMIS_DW,
  parameter int VW = RMIS_VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           state,
  input  logic          step,
  input  logic          accept,
  input  logic          setif,
  input  logic          ld_go,
  input  op_e           op,
  input  logic [VW-1:0] vec_in,
  input  logic [DW-1:0] imm_in,
  input  logic [DW-1:0] ld_flags,
  input  logic [DW-1:0] ld_cs,
  input  logic [DW-1:0] ld_ip,
  input  logic [DW-1:0] ld_sp,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] flags,
  output logic [DW-1:0] cs,
  output logic [DW-1:0] ip,
  output logic [DW-1:0] sp,
  output logic [VW-1:0] vec
);
  localparam logic [DW-1:0] WSTEP = DW'(2);

  logic [DW-1:0] flags_q, cs_q, ip_q, sp_q, tip_q, tcs_q, imm_q;
  logic [DW-1:0] flags_d, cs_d, ip_d, sp_d, tip_d, tcs_d, imm_d;
  logic [VW-1:0] vec_q, vec_d;
  logic          upd;
  logic          fin;

  assign fin = (state == ST_FIN);
  assign upd = ld_go | setif | accept | step | fin;

  always_comb begin
    flags_d = flags_q; cs_d = cs_q; ip_d = ip_q; sp_d = sp_q;
    tip_d = tip_q; tcs_d = tcs_q; imm_d = imm_q; vec_d = vec_q;
    if (ld_go) begin
      flags_d = ld_flags; cs_d = ld_cs; ip_d = ld_ip; sp_d = ld_sp;
    end else if (setif) begin
      flags_d[RMIS_IF_BIT] = 1'b1;
    end else if (accept) begin
      vec_d = vec_in;
      imm_d = imm_in;
      tcs_d = cs_q;
      if (op == OP_INT) sp_d = sp_q - WSTEP;
    end else if (fin) begin
      ip_d = tip_q;
      cs_d = tcs_q;
      sp_d = sp_q + imm_q;
    end else if (step) begin
      case (state)
        ST_PUSH_F: begin
          flags_d[RMIS_TF_BIT] = 1'b0;
          flags_d[RMIS_IF_BIT] = 1'b0;
          sp_d = sp_q - WSTEP;
        end
        ST_PUSH_CS: sp_d = sp_q - WSTEP;
        ST_RD_IP:   tip_d = rdata;
        ST_RD_CS: begin
          cs_d = rdata;
          ip_d = tip_q;
        end
        ST_POP_IP: begin
          tip_d = rdata;
          sp_d  = sp_q + WSTEP;
        end
        ST_POP_CS: begin
          tcs_d = rdata;
          sp_d  = sp_q + WSTEP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0; cs_q <= '0; ip_q <= '0; sp_q <= '0;
      tip_q <= '0; tcs_q <= '0; imm_q <= '0; vec_q <= '0;
    end else if (upd) begin
      flags_q <= flags_d; cs_q <= cs_d; ip_q <= ip_d; sp_q <= sp_d;
      tip_q <= tip_d; tcs_q <= tcs_d; imm_q <= imm_d; vec_q <= vec_d;
    end
  end

  assign flags = flags_q;
  assign cs    = cs_q;
  assign ip    = ip_q;
  assign sp    = sp_q;
  assign vec   = vec_q;
endmodule

// File: rtl/rm_irq_seq.sv
module rm_irq_seq
  import rmis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_vec,
  input  logic [15:0] req_imm,
  input  logic        ld_en,
  input  logic [15:0] ld_flags,
  input  logic [15:0] ld_cs,
  input  logic [15:0] ld_ip,
  input  logic [15:0] ld_sp,
  input  logic [15:0] ss_i,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_rdy,
  output logic [15:0] flags_o,
  output logic [15:0] cs_o,
  output logic [15:0] ip_o,
  output logic [15:0] sp_o
);
  logic       rst_m, rst_s;
  st_e        state;
  op_e        op;
  logic       idle, accept, setif, ld_go, step;
  logic [7:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign op     = op_e'(req_op);
  assign idle   = (state == ST_IDLE);
  assign ld_go  = idle & ld_en;
  assign setif  = idle & ~ld_en & req_valid & (op == OP_SETIF);
  assign accept = idle & ~ld_en & req_valid & (op != OP_SETIF);
  assign step   = mem_req & mem_rdy;
  assign busy   = ~idle;

  rmis_fsm u_fsm (
    .clk(clk), .rst_n(rst_s), .accept(accept), .op(op), .step(step), .state(state)
  );

  rmis_agen #(.DW(RMIS_DW), .AW(RMIS_AW), .VW(RMIS_VW)) u_agen (
    .state(state), .ss(ss_i), .sp(sp_o), .vec(vec_q),
    .flags(flags_o), .cs(cs_o), .ip(ip_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  rmis_regs #(.DW(RMIS_DW), .VW(RMIS_VW)) u_regs (
    .clk(clk), .rst_n(rst_s), .state(state), .step(step), .accept(accept),
    .setif(setif), .ld_go(ld_go), .op(op), .vec_in(req_vec), .imm_in(req_imm),
    .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_sp(ld_sp),
    .rdata(mem_rdata), .flags(flags_o), .cs(cs_o), .ip(ip_o), .sp(sp_o), .vec(vec_q)
  );
endmodule

// File: rtl/rmis_chk.sv
module rmis_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic        ld_en,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_rdy,
  input logic [19:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] flags_o,
  input logic [15:0] cs_o
);
  logic [1:0] kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= 2'b11;
    else if (!busy && req_valid && !ld_en) kind_q <= req_op;
  end

  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r8_req_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r7_setif_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && !ld_en && req_op == 2'b11 |=> flags_o[9] && !busy && !mem_req);

  a_r6_near_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind_q == 2'b01 |=> cs_o == $past(cs_o));

  a_r3_flags_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && kind_q == 2'b00 |-> !flags_o[8] && !flags_o[9]);
endmodule

bind rm_irq_seq rmis_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .ld_en(ld_en),
  .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_rdy(mem_rdy),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .flags_o(flags_o), .cs_o(cs_o)
);

// File: tb/tb_rm_irq_seq.sv
`timescale 1ns/1ps
module tb_rm_irq_seq;
  localparam real TCK = 20.0;

  logic        clk, rst_n;
  logic        req_valid, ld_en, mem_rdy;
  logic [1:0]  req_op;
  logic [7:0]  req_vec;
  logic [15:0] req_imm, ld_flags, ld_cs, ld_ip, ld_sp, ss_i, mem_rdata;
  logic        busy, mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, flags_o, cs_o, ip_o, sp_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit stall_en = 0;
  bit done = 0;

  typedef struct packed { logic we; logic [19:0] a; logic [15:0] d; } xfer_t;
  xfer_t exp_q[$];
  string tag_q[$];
  logic [15:0] mem [logic [19:0]];

  rm_irq_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_vec(req_vec),
    .req_imm(req_imm), .ld_en(ld_en), .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip),
    .ld_sp(ld_sp), .ss_i(ss_i), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o)
  );

  initial clk = 0;
  always #(TCK/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return 16'hDEAD;
  endfunction

  // memory model: inputs move at negedge only
  always @(negedge clk) begin
    cyc++;
    mem_rdy   <= stall_en ? (cyc % 3 == 0) : 1'b1;
    mem_rdata <= rd(mem_addr);
  end

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_rdy) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected transfer", {12'h0, mem_addr}, 32'hFFFFFFFF);
      end else begin
        xfer_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " addr"}, {11'h0, mem_we, mem_addr}, {11'h0, e.we, e.a});
        if (e.we) chk({t, " wdata"}, {16'h0, mem_wdata}, {16'h0, e.d});
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] p);
    return ({4'h0, s} << 4) + {4'h0, p};
  endfunction

  task automatic expect_x(string t, logic we, logic [19:0] a, logic [15:0] d);
    exp_q.push_back('{we: we, a: a, d: d});
    tag_q.push_back(t);
  endtask

  task automatic load(logic [15:0] f, logic [15:0] c, logic [15:0] i, logic [15:0] s);
    @(negedge clk);
    ld_en = 1; ld_flags = f; ld_cs = c; ld_ip = i; ld_sp = s;
    @(negedge clk);
    ld_en = 0;
  endtask

  // issue a request; when noise is set, throw in a request and a load mid-sequence
  task automatic run(logic [1:0] op, logic [7:0] v, logic [15:0] imm, bit noise);
    @(negedge clk);
    req_valid = 1; req_op = op; req_vec = v; req_imm = imm;
    @(negedge clk);
    req_valid = 0;
    chk("R8 busy after accept", {31'h0, busy}, 32'h1);
    if (noise) begin
      @(negedge clk);
      req_valid = 1; req_op = 2'b10; ld_en = 1; ld_flags = 16'hFFFF;
      ld_cs = 16'hFFFF; ld_ip = 16'hFFFF; ld_sp = 16'hFFFF;
      @(negedge clk);
      req_valid = 0; ld_en = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_int(logic [7:0] v, logic [15:0] ss, bit noise);
    logic [15:0] f0, c0, i0, s0;
    f0 = flags_o; c0 = cs_o; i0 = ip_o; s0 = sp_o;
    expect_x("R2 push FLAGS", 1, phys(ss, s0 - 16'd2), f0);
    expect_x("R2 push CS",    1, phys(ss, s0 - 16'd4), c0);
    expect_x("R2 push IP",    1, phys(ss, s0 - 16'd6), i0);
    expect_x("R4 read IP",    0, {10'h0, v, 2'b00}, 16'h0);
    expect_x("R4 read CS",    0, {10'h0, v, 2'b10}, 16'h0);
    run(2'b00, v, 16'h0, noise);
    chk("R3 flags", {16'h0, flags_o}, {16'h0, f0 & 16'hFCFF});
    chk("R3 sp", {16'h0, sp_o}, {16'h0, s0 - 16'd6});
    chk("R4 ip", {16'h0, ip_o}, {16'h0, mem[{10'h0, v, 2'b00}]});
    chk("R4 cs", {16'h0, cs_o}, {16'h0, mem[{10'h0, v, 2'b10}]});
    chk("R8 queue drained", exp_q.size(), 0);
  endtask

  task automatic do_ret(bit far, logic [15:0] imm, logic [15:0] ss);
    logic [15:0] f0, c0, s0, ni, nc;
    f0 = flags_o; c0 = cs_o; s0 = sp_o;
    ni = rd(phys(ss, s0));
    nc = far ? rd(phys(ss, s0 + 16'd2)) : c0;
    if (far) begin
      expect_x("R5 pop IP", 0, phys(ss, s0), 16'h0);
      expect_x("R5 pop CS", 0, phys(ss, s0 + 16'd2), 16'h0);
    end else begin
      expect_x("R6 pop IP", 0, phys(ss, s0), 16'h0);
    end
    run(far ? 2'b10 : 2'b01, 8'h0, imm, 0);
    chk(far ? "R5 ip" : "R6 ip", {16'h0, ip_o}, {16'h0, ni});
    chk(far ? "R5 cs" : "R6 cs", {16'h0, cs_o}, {16'h0, nc});
    chk(far ? "R5 sp" : "R6 sp", {16'h0, sp_o},
        {16'h0, s0 + (far ? 16'd4 : 16'd2) + imm});
    chk("R6 flags kept", {16'h0, flags_o}, {16'h0, f0});
    chk("R8 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_vec = 0; req_imm = 0; ld_en = 0;
    ld_flags = 0; ld_cs = 0; ld_ip = 0; ld_sp = 0; ss_i = 16'h2000;
    mem_rdy = 1; mem_rdata = 0;
    mem[20'h00084] = 16'h5678; mem[20'h00086] = 16'h9ABC;
    mem[20'h003FC] = 16'hAAAA; mem[20'h003FE] = 16'hBBBB;
    mem[20'h00010] = 16'h4321;
    #(TCK * 3.3);
    chk("R1 busy in reset", {31'h0, busy}, 0);
    chk("R1 mem_req in reset", {31'h0, mem_req}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 regs after reset", {flags_o, cs_o} | {ip_o, sp_o}, 0);
    chk("R1 idle after reset", {30'h0, busy, mem_req}, 0);

    // R10: load, and load beats a simultaneous request
    @(negedge clk);
    ld_en = 1; ld_flags = 16'h0302; ld_cs = 16'h1234; ld_ip = 16'h0100; ld_sp = 16'h0100;
    req_valid = 1; req_op = 2'b00; req_vec = 8'h21;
    @(negedge clk);
    ld_en = 0; req_valid = 0;
    chk("R10 load wins busy", {31'h0, busy}, 0);
    chk("R10 load values", {flags_o, cs_o}, 32'h0302_1234);
    chk("R10 load values ip/sp", {ip_o, sp_o}, 32'h0100_0100);
    @(negedge clk);
    chk("R10 dropped request", {31'h0, busy | mem_req}, 0);

    // R2 R3 R4 interrupt, ready always high
    do_int(8'h21, ss_i, 0);
    // R5 far return releasing 4 bytes
    do_ret(1, 16'd4, ss_i);
    // R7 set interrupt enable
    @(negedge clk);
    req_valid = 1; req_op = 2'b11;
    @(negedge clk);
    req_valid = 0;
    chk("R7 flags", {16'h0, flags_o}, 32'h0202);
    chk("R7 no busy", {30'h0, busy, mem_req}, 0);
    chk("R7 others kept", {cs_o, ip_o}, 32'h1234_0100);

    // R2 SP wrap from 0, vector FF, stalls (R9), noise while busy (R8)
    load(16'h0100, 16'h0001, 16'h0002, 16'h0000);
    stall_en = 1;
    do_int(8'hFF, ss_i, 1);
    // R6 near return with no release, still stalled
    do_ret(0, 16'd0, ss_i);
    stall_en = 0;
    // R6 near return across the 2^20 physical wrap, release 6
    ss_i = 16'hFFFF;
    load(16'h0000, 16'h7777, 16'h0000, 16'h0020);
    do_ret(0, 16'd6, ss_i);
    chk("R9 wrapped pop ip", {16'h0, ip_o}, 32'h4321);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule